// File: doc/BRIEF.md
# Range-Addressed Hyperbolic Tangent Unit

This block is the activation stage of a small fixed-point neural datapath, attached to a host processor as one custom instruction. The host hands it a 32-bit operand word and a lane-mode bit. It returns a 32-bit word in which every lane carries the hyperbolic tangent of the matching input lane. The mode bit selects between two 16-bit lanes and four 8-bit lanes, so one issue evaluates either two or four activations.

Each lane does not index one large table. It takes the magnitude of its input and finds the position of the leading one. That position picks a range, and a fixed number of bits just below the leading one pick an entry inside that range's short table segment. Very small magnitudes skip the table and pass through a linear path, because tanh(x) is close to x there. Magnitudes of 4.0 and above saturate. The sign is put back at the end, so the transfer curve is exactly odd.

The table contents are worked out from the parameters while the design elaborates. The operand is captured when start is seen. The result is registered one cycle later, and done marks that cycle.

Top module: `tanh_rl_unit`

## Requirements
- R1: When start is sampled high on a clock edge, done is high for exactly one cycle, after the second following edge. Done is never high unless start was sampled two edges earlier.
- R2: With mode = 0, operand bits [15:0] and [31:16] are two signed Q3.12 inputs (12 fraction bits). Result bits [15:0] and [31:16] hold their tanh values as signed Q0.15.
- R3: With mode = 1, operand byte k (bits [8k+7:8k], k = 0..3) is a signed Q2.5 input (5 fraction bits). Result byte k holds its tanh value as signed Q0.7.
- R4: Outside the exact regions of R6 to R8, each 16-bit lane output is within 256 LSB of round(tanh(x)·2^15), and each 8-bit lane output is within 5 LSB of round(tanh(x)·2^7).
- R5: For any lane input x other than the most negative code, the output for -x is exactly the two's complement negation of the output for x.
- R6: A lane input of zero gives a lane output of exactly zero.
- R7: A lane whose magnitude is 4.0 or more (|x| ≥ 16384 LSB in 16-bit lanes, |x| ≥ 128 LSB in 8-bit lanes) gives +0x7FFF / +0x7F, or -0x7FFF (0x8001) / -0x7F (0x81) when x is negative.
- R8: A nonzero lane with |x| < 32 LSB (16-bit) or |x| < 8 LSB (8-bit) gives exactly x·8 (16-bit) or x·4 (8-bit).
- R9: Within one mode, the lane output is non-decreasing as the signed lane input increases.
- R10: The result holds its value in every cycle in which done is low.
- R11: Starts in consecutive cycles each complete two cycles later, in issue order. Each result uses the operand and mode sampled with its own start.
- R12: While reset is asserted, and after it is released until the first completion, done is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Issue strobe for one evaluation |
| mode | input | 1 | Lane split: 0 = two 16-bit lanes, 1 = four 8-bit lanes |
| operand | input | 32 | Packed signed lane inputs |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed signed tanh outputs, held until the next completion |

## Verification
The bench aims at the seams between the three lane regions. At 31/32 and 16383/16384 in a 16-bit lane, and at 7/8 and 127/-128 in an 8-bit lane, an off-by-one in the range decode would send a value through the wrong path. That shows up as a missing exact scale, a saturation that comes too early, or a step backwards in the monotonic sweeps. The most negative codes catch a magnitude stage that overflows when it negates. Paired ±x lanes catch a sign restore that is rounded or applied unevenly, and the zero inputs catch an offset from the table. Issues in consecutive cycles with alternating modes would expose a pipeline that mixes one instruction's mode or operand with the next one's, or that pulses done at the wrong time.

// File: rtl/tanh_rl_pkg.sv
package tanh_rl_pkg;

  typedef enum logic {
    LANES_HALF = 1'b0,
    LANES_BYTE = 1'b1
  } lane_mode_e;

  localparam int WORD_W = 32;
  localparam longint Q30_ONE = 64'sd1073741824;

  // exp(-z) with z in Q30, z < 2^33: Taylor series on z/16, then four squarings
  function automatic longint exp_neg_q30(input longint z);
    longint zr;
    longint acc;
    longint term;
    zr   = z >>> 4;
    acc  = Q30_ONE;
    term = Q30_ONE;
    for (int n = 1; n <= 16; n++) begin
      term = -((term * zr) / (longint'(n) <<< 30));
      acc  = acc + term;
    end
    for (int s = 0; s < 4; s++) begin
      acc = (acc * acc) >>> 30;
    end
    return acc;
  endfunction

  // rounded tanh of x_lsb / 2^in_frac, scaled by 2^out_frac and clamped below 1.0
  function automatic int tanh_point(input int x_lsb, input int in_frac, input int out_frac);
    longint z;
    longint e;
    longint num;
    longint den;
    longint q;
    z   = longint'(x_lsb) <<< (31 - in_frac);
    e   = exp_neg_q30(z);
    num = (Q30_ONE - e) <<< out_frac;
    den = Q30_ONE + e;
    q   = (num + (den >>> 1)) / den;
    if (q > ((64'sd1 <<< out_frac) - 1)) q = (64'sd1 <<< out_frac) - 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/tanh_rl_lead.sv
module tanh_rl_lead #(
  parameter int W     = 16,
  parameter int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     mag,
  output logic [POS_W-1:0] pos,
  output logic             any
);

  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    pos = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (mag[i]) begin
        pos = POS_W'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tanh_rl_seg_rom.sv
module tanh_rl_seg_rom #(
  parameter int DATA_W  = 16,
  parameter int IN_FRAC = 12,
  parameter int IDX_W   = 5,
  parameter int LIN_POS = 5,
  parameter int SAT_POS = 14,
  parameter int POS_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] mag,
  input  logic [POS_W-1:0]  pos,
  output logic [DATA_W-2:0] entry
);

  localparam int OUT_FRAC = DATA_W - 1;
  localparam int SEG_LEN  = 1 << IDX_W;
  localparam int ROWS     = SAT_POS - LIN_POS;
  localparam int ENTRIES  = ROWS * SEG_LEN;
  localparam int ADDR_W   = $clog2(ENTRIES);

  // one segment per leading-one position; samples taken at segment midpoints
  function automatic logic [ENTRIES*OUT_FRAC-1:0] build_tbl();
    logic [ENTRIES*OUT_FRAC-1:0] t;
    int p;
    int step;
    int mid;
    t = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < SEG_LEN; c++) begin
        p    = r + LIN_POS;
        step = 1 << (p - IDX_W);
        mid  = (1 << p) + c * step + (step >> 1);
        t[(r*SEG_LEN + c)*OUT_FRAC +: OUT_FRAC] =
          OUT_FRAC'(tanh_rl_pkg::tanh_point(mid, IN_FRAC, OUT_FRAC));
      end
    end
    return t;
  endfunction

  localparam logic [ENTRIES*OUT_FRAC-1:0] SEG_TBL = build_tbl();

  logic [POS_W-1:0]  row;
  logic [IDX_W-1:0]  col;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    if (pos >= POS_W'(LIN_POS) && pos < POS_W'(SAT_POS)) begin
      row = pos - POS_W'(LIN_POS);
      col = IDX_W'(mag >> (pos - POS_W'(IDX_W)));
    end else begin
      row = '0;
      col = '0;
    end
    addr  = (ADDR_W'(row) << IDX_W) | ADDR_W'(col);
    entry = SEG_TBL[int'(addr)*OUT_FRAC +: OUT_FRAC];
  end

endmodule

// File: rtl/tanh_rl_lane.sv
module tanh_rl_lane #(
  parameter int DATA_W  = 16,
  parameter int IN_FRAC = 12,
  parameter int IDX_W   = 5,
  parameter int LIN_POS = 5,
  parameter int SAT_POS = 14
) (
  input  logic [DATA_W-1:0] x_in,
  output logic [DATA_W-1:0] y_out
);

  localparam int OUT_FRAC = DATA_W - 1;
  localparam int POS_W    = $clog2(DATA_W);
  localparam int SHIFT    = OUT_FRAC - IN_FRAC;
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {OUT_FRAC{1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(OUT_FRAC-1){1'b0}}, 1'b1};

  logic                neg;
  logic [DATA_W-1:0]   mag;
  logic [POS_W-1:0]    pos;
  logic                any;
  logic [OUT_FRAC-1:0] tbl_val;
  logic [OUT_FRAC-1:0] mag_out;
  logic [DATA_W-1:0]   mag_ext;

  // odd symmetry: evaluate on the magnitude (full width holds 2^(DATA_W-1))
  always_comb begin
    neg = x_in[DATA_W-1];
    mag = neg ? (~x_in + DATA_W'(1)) : x_in;
  end

  tanh_rl_lead #(.W(DATA_W), .POS_W(POS_W)) u_lead (
    .mag (mag),
    .pos (pos),
    .any (any)
  );

  tanh_rl_seg_rom #(
    .DATA_W (DATA_W), .IN_FRAC (IN_FRAC), .IDX_W (IDX_W),
    .LIN_POS(LIN_POS), .SAT_POS(SAT_POS), .POS_W(POS_W)
  ) u_rom (
    .mag   (mag),
    .pos   (pos),
    .entry (tbl_val)
  );

  always_comb begin
    if (!any || pos < POS_W'(LIN_POS)) begin
      mag_out = OUT_FRAC'(mag << SHIFT);
    end else if (pos >= POS_W'(SAT_POS)) begin
      mag_out = {OUT_FRAC{1'b1}};
    end else begin
      mag_out = tbl_val;
    end
    mag_ext = {1'b0, mag_out};
    y_out   = neg ? (~mag_ext + DATA_W'(1)) : mag_ext;
  end

  always_comb begin
    if (x_in == '0) begin
      assert_zero_exact_R6: assert (y_out == '0)
        else $error("zero input produced nonzero output");
    end
    if (any && pos >= POS_W'(SAT_POS)) begin
      assert_sat_clamp_R7: assert (y_out == (neg ? NEG_MAX : POS_MAX))
        else $error("saturated lane not at full scale");
    end
    if (any && pos < POS_W'(LIN_POS)) begin
      assert_linear_exact_R8: assert (y_out == DATA_W'(x_in << SHIFT))
        else $error("small input not passed linearly");
    end
  end

endmodule

// File: rtl/tanh_rl_unit.sv
module tanh_rl_unit #(
  parameter int H_IN_FRAC = 12,
  parameter int H_IDX_W   = 5,
  parameter int H_LIN_POS = 5,
  parameter int H_SAT_POS = 14,
  parameter int B_IN_FRAC = 5,
  parameter int B_IDX_W   = 3,
  parameter int B_LIN_POS = 3,
  parameter int B_SAT_POS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mode,
  input  logic [31:0] operand,
  output logic        done,
  output logic [31:0] result
);

  import tanh_rl_pkg::*;

  localparam int HALF_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int HALF_LANES = WORD_W / HALF_W;
  localparam int BYTE_LANES = WORD_W / BYTE_W;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // stage 1: operand capture
  logic              issue_q, issue_d;
  logic [WORD_W-1:0] op_q, op_d;
  lane_mode_e        mode_q, mode_d;
  // stage 2: registered result
  logic              done_q, done_d;
  logic [WORD_W-1:0] res_q, res_d;

  logic [WORD_W-1:0] half_word;
  logic [WORD_W-1:0] byte_word;
  logic [WORD_W-1:0] lane_word;

  generate
    for (genvar g = 0; g < HALF_LANES; g++) begin : g_half
      tanh_rl_lane #(
        .DATA_W(HALF_W), .IN_FRAC(H_IN_FRAC), .IDX_W(H_IDX_W),
        .LIN_POS(H_LIN_POS), .SAT_POS(H_SAT_POS)
      ) u_lane (
        .x_in  (op_q[g*HALF_W +: HALF_W]),
        .y_out (half_word[g*HALF_W +: HALF_W])
      );
    end
    for (genvar g = 0; g < BYTE_LANES; g++) begin : g_byte
      tanh_rl_lane #(
        .DATA_W(BYTE_W), .IN_FRAC(B_IN_FRAC), .IDX_W(B_IDX_W),
        .LIN_POS(B_LIN_POS), .SAT_POS(B_SAT_POS)
      ) u_lane (
        .x_in  (op_q[g*BYTE_W +: BYTE_W]),
        .y_out (byte_word[g*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

  always_comb begin
    lane_word = (mode_q == LANES_BYTE) ? byte_word : half_word;
    issue_d   = start;
    op_d      = start ? operand : op_q;
    mode_d    = start ? lane_mode_e'(mode) : mode_q;
    done_d    = issue_q;
    res_d     = issue_q ? lane_word : res_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      issue_q <= 1'b0;
      op_q    <= '0;
      mode_q  <= LANES_HALF;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      issue_q <= issue_d;
      op_q    <= op_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
      res_q   <= res_d;
    end
  end

  assign done   = done_q;
  assign result = res_q;

  assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |-> ##2 done);

  assert_done_cause_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> $past(start, 2));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(result) |-> done);

endmodule

// File: tb/tanh_rl_unit_tb.sv
module tanh_rl_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        mode;
  logic [31:0] operand;
  logic        done;
  logic [31:0] result;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tanh_rl_unit u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .operand (operand),
    .done    (done),
    .result  (result)
  );

  task automatic expect_eq(input string req, input int got, input int exp_v);
    vectors++;
    if (got != exp_v) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp_v);
    end
  endtask

  function automatic int ref_tanh(input int x, input int dw, input int ifr);
    real r;
    int  q;
    int  mx;
    r  = $tanh(real'(x) / real'(1 << ifr)) * real'(1 << (dw - 1));
    q  = $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
    mx = (1 << (dw - 1)) - 1;
    if (q > mx) q = mx;
    if (q < -mx) q = -mx;
    return q;
  endfunction

  // one lane against R4/R6/R7/R8, tagged with the mode requirement
  task automatic check_lane(input bit m, input int x, input int got, input string tag);
    int dw, ifr, lin, sat, sh, mx, tol, ax, e;
    dw  = m ? 8 : 16;
    ifr = m ? 5 : 12;
    lin = m ? 8 : 32;
    sat = m ? 128 : 16384;
    sh  = m ? 4 : 8;
    tol = m ? 5 : 256;
    mx  = (1 << (dw - 1)) - 1;
    ax  = (x < 0) ? -x : x;
    vectors++;
    if (x == 0) begin
      if (got != 0) begin
        fails++;
        $display("FAIL R6 %s x=%0d: got %0d expected 0", tag, x, got);
      end
    end else if (ax < lin) begin
      if (got != x * sh) begin
        fails++;
        $display("FAIL R8 %s x=%0d: got %0d expected %0d", tag, x, got, x * sh);
      end
    end else if (ax >= sat) begin
      e = (x < 0) ? -mx : mx;
      if (got != e) begin
        fails++;
        $display("FAIL R7 %s x=%0d: got %0d expected %0d", tag, x, got, e);
      end
    end else begin
      e = ref_tanh(x, dw, ifr);
      if (got > e + tol || got < e - tol) begin
        fails++;
        $display("FAIL R4 %s x=%0d: got %0d expected %0d +/- %0d", tag, x, got, e, tol);
      end
    end
  endtask

  task automatic check_word(input bit m, input logic [31:0] op, input logic [31:0] res);
    if (!m) begin
      for (int g = 0; g < 2; g++)
        check_lane(1'b0, int'($signed(op[g*16 +: 16])), int'($signed(res[g*16 +: 16])), "R2");
    end else begin
      for (int g = 0; g < 4; g++)
        check_lane(1'b1, int'($signed(op[g*8 +: 8])), int'($signed(res[g*8 +: 8])), "R3");
    end
  endtask

  // issue one instruction at a falling edge and collect its result (R1, R10)
  task automatic run_op(input bit m, input logic [31:0] op, output logic [31:0] res);
    start = 1'b1; mode = m; operand = op;
    @(negedge clk);
    start = 1'b0; operand = $urandom; mode = $urandom;
    expect_eq("R1 done early", int'(done), 0);
    @(negedge clk);
    expect_eq("R1 done on time", int'(done), 1);
    res = result;
    @(negedge clk);
    expect_eq("R1 done one cycle", int'(done), 0);
    expect_eq("R10 result held", int'(result == res), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] res, ra, rb, rc, held;
    int prev;
    int cur;
    int x;
    logic [31:0] opa, opb, opc;
    int corners16 [14] = '{0, 1, -1, 31, -31, 32, -32, 4096, -4096,
                           16383, -16383, 16384, -32768, 32767};
    int corners8 [12]  = '{0, 1, -1, 7, -7, 8, -8, 32, -32, 127, -127, -128};
    void'($urandom(32'd7021));
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; operand = '0;
    repeat (4) @(negedge clk);
    expect_eq("R12 done in reset", int'(done), 0);
    expect_eq("R12 result in reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_eq("R12 done after release", int'(done), 0);
    expect_eq("R12 result after release", int'(result), 0);

    // directed corners: 16-bit lanes (R2, R6, R7, R8)
    foreach (corners16[i]) begin
      opa = {16'(corners16[(i + 1) % 14]), 16'(corners16[i])};
      run_op(1'b0, opa, res);
      check_word(1'b0, opa, res);
    end
    // directed corners: 8-bit lanes (R3, R6, R7, R8)
    foreach (corners8[i]) begin
      opa = {8'(corners8[(i + 3) % 12]), 8'(corners8[(i + 2) % 12]),
             8'(corners8[(i + 1) % 12]), 8'(corners8[i])};
      run_op(1'b1, opa, res);
      check_word(1'b1, opa, res);
    end

    // R9: full 8-bit sweep, all lanes identical and non-decreasing
    prev = -1000;
    for (int v = -128; v < 128; v++) begin
      opa = {4{8'(v)}};
      run_op(1'b1, opa, res);
      check_word(1'b1, opa, res);
      cur = int'($signed(res[7:0]));
      expect_eq("R3 lanes agree", int'(res == {4{res[7:0]}}), 1);
      if (cur < prev) begin
        vectors++; fails++;
        $display("FAIL R9 8-bit x=%0d: got %0d expected >= %0d", v, cur, prev);
      end
      prev = cur;
    end

    // R9: strided 16-bit sweep
    prev = -100000;
    for (int v = -32768; v < 32768; v += 61) begin
      opa = {16'(v), 16'(v)};
      run_op(1'b0, opa, res);
      check_word(1'b0, opa, res);
      cur = int'($signed(res[15:0]));
      if (cur < prev) begin
        vectors++; fails++;
        $display("FAIL R9 16-bit x=%0d: got %0d expected >= %0d", v, cur, prev);
      end
      prev = cur;
    end

    // R5: paired +x / -x lanes
    for (int i = 0; i < 100; i++) begin
      x = int'($urandom_range(32767, 0));
      opa = {16'(-x), 16'(x)};
      run_op(1'b0, opa, res);
      expect_eq("R5 16-bit symmetry", int'($signed(res[31:16])), -int'($signed(res[15:0])));
      x = int'($urandom_range(127, 0));
      opa = {8'(-x), 8'(x), 8'(x), 8'(-x)};
      run_op(1'b1, opa, res);
      expect_eq("R5 8-bit symmetry", int'($signed(res[15:8])), -int'($signed(res[31:24])));
      expect_eq("R5 8-bit symmetry", int'($signed(res[7:0])), -int'($signed(res[23:16])));
    end

    // random stimulus in both modes (R2, R3, R4)
    for (int i = 0; i < 300; i++) begin
      opa = $urandom;
      cur = int'($urandom_range(1, 0));
      run_op(cur[0], opa, res);
      check_word(cur[0], opa, res);
    end

    // R11: back-to-back issues with alternating modes
    for (int i = 0; i < 20; i++) begin
      opa = $urandom; opb = $urandom; opc = $urandom;
      start = 1'b1; mode = 1'b0; operand = opa;
      @(negedge clk);
      mode = 1'b1; operand = opb;
      @(negedge clk);
      expect_eq("R11 done first", int'(done), 1);
      ra = result;
      mode = 1'b0; operand = opc;
      @(negedge clk);
      expect_eq("R11 done second", int'(done), 1);
      rb = result;
      start = 1'b0;
      @(negedge clk);
      expect_eq("R11 done third", int'(done), 1);
      rc = result;
      @(negedge clk);
      expect_eq("R11 done drops", int'(done), 0);
      check_word(1'b0, opa, ra);
      check_word(1'b1, opb, rb);
      check_word(1'b0, opc, rc);
    end

    // R10: idle cycles with changing inputs leave result untouched
    held = result;
    for (int i = 0; i < 6; i++) begin
      operand = $urandom; mode = $urandom;
      @(negedge clk);
      expect_eq("R10 idle hold", int'(result == held), 1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule